// File: doc/BRIEF.md
# Adaptive-Precision Systolic Multiply Array

This block is an N×N weight-stationary systolic array. It multiplies signed 8-bit activations by weights whose precision is chosen at run time: 8, 4 or 2 bits. Every processing element stores one 8-bit weight word and breaks it into four 2-bit slices. It forms one 8×2-bit partial product per slice and passes four slice sums down its column. The shifters and accumulators are not inside the elements. Each column has one set at the bottom edge. In 8-bit mode they fuse the four slice sums into one product. In the narrower modes they keep two or four independent sums, one for each packed weight matrix. One activation stream is therefore multiplied against one, two or four weight matrices in the same pass.

To use the block, load the weights one column per cycle while the array is idle. Then pulse `start` with the precision and the tile length. After that, stream the activation vectors with `act_valid`, one vector per accepted beat. Row i of the array sees its activation i cycles late, and each activation moves one element to the right per cycle. Every column lane accumulates the sum over all vectors and all rows of activation × weight. `done` then pulses for one cycle, and at that moment the results are final.

Top module: `apsa_top`

## Requirements
- R1: After reset, `busy` and `done` are low and every lane of `result` reads zero.
- R2: Mode code 0 (8-bit weights): lane 0 of column j holds Σk Σi a[k][i]·w[i][j]. Both operands are signed two's complement, including −128×−128. Lanes 1 to 3 read zero.
- R3: Mode code 1 (4-bit weights): lane m (m = 0, 1) of column j uses the signed nibble at bits [4m+3:4m] of each weight word. Lanes 2 and 3 read zero.
- R4: Mode code 2 (2-bit weights): lane m (m = 0..3) of column j uses the signed pair at bits [2m+1:2m] of each weight word. For example, pair value 2'b10 means −2.
- R5: `busy` is high from the clock edge that accepts `start` until the tile ends. `done` is a one-cycle pulse, seen 2N−1 clock edges after the edge that accepts the last activation vector, and `busy` is low in that same cycle.
- R6: Accepting `start` clears every accumulator. A tile's results hold no contribution from an earlier tile.
- R7: The precision is latched when `start` is accepted. Changes on `mode_sel` during a tile have no effect on that tile.
- R8: Weight loads are ignored while `busy` is high. The stored weights are unchanged for the current tile and for later tiles.
- R9: During a tile, a cycle with `act_valid` low adds nothing to the results and does not count toward `tile_len`. Whatever is on `act_vec` in that cycle is ignored.
- R10: Activation row i is bits [8i+7:8i] of `act_vec`. Weight row i is bits [8i+7:8i] of `w_word`, written to column `w_col`. Column j, lane l is bits [32(4j+l)+31:32(4j+l)] of `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a tile when idle |
| mode_sel | input | 2 | Precision code: 0 = 8-bit, 1 = 4-bit, 2 = 2-bit weights |
| tile_len | input | 16 | Number of activation vectors in the tile (0 is treated as 1) |
| w_load | input | 1 | Writes one weight column when idle |
| w_col | input | 2 | Column index for a weight write |
| w_word | input | 32 | One weight word for each row of the addressed column |
| act_valid | input | 1 | Marks `act_vec` as a tile beat |
| act_vec | input | 32 | One signed activation for each row |
| busy | output | 1 | A tile is in progress |
| done | output | 1 | One-cycle pulse when the results are final |
| result | output | 512 | Four 32-bit signed lanes for each column |

## Verification
Each slice has its own shift weight and signedness, so a wrong sign mask or shift for one slice distorts only some weight values and only some lanes. The sweep over every weight byte with extreme activations brings such an error out on the lane concerned at the next `done`. A stale accumulator, a miscounted beat or a mode or weight change taken mid-tile changes the final sums. It shows as a wrong `result` in the same cycle as `done`. A wrong skew or drain depth moves `done` away from its fixed distance of 2N−1 edges, or drops the last column's partial products from the sums.

// File: rtl/apsa_pkg.sv
package apsa_pkg;

  typedef enum logic [1:0] {
    PM_W8  = 2'd0,
    PM_W4  = 2'd1,
    PM_W2  = 2'd2,
    PM_RSV = 2'd3
  } prec_mode_e;

  localparam int ACT_W   = 8;
  localparam int WORD_W  = 8;
  localparam int SLICE_W = 2;
  localparam int SLICES  = WORD_W / SLICE_W;
  localparam int PROD_W  = ACT_W + SLICE_W;

  // Which slices take their top bit as a sign bit in each precision.
  function automatic logic [SLICES-1:0] slice_sign_mask(prec_mode_e m);
    case (m)
      PM_W4:   return 4'b1010;
      PM_W2:   return 4'b1111;
      default: return 4'b1000;
    endcase
  endfunction

  // Signed activation times a 2-bit slice, which is signed or unsigned.
  function automatic logic signed [PROD_W-1:0] slice_mul(logic signed [ACT_W-1:0] a,
                                                         logic [SLICE_W-1:0] b,
                                                         logic is_signed);
    logic signed [SLICE_W:0] bx;
    bx = {is_signed & b[SLICE_W-1], b};
    return a * bx;
  endfunction

endpackage

// File: rtl/apsa_skew.sv
module apsa_skew #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N*DW-1:0] vec_in,
  output logic [N*DW-1:0] vec_out
);
  for (genvar i = 0; i < N; i++) begin : g_row
    if (i == 0) begin : g_direct
      assign vec_out[DW-1:0] = vec_in[DW-1:0];
    end else begin : g_delay
      logic [DW-1:0] pipe [i];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < i; s++) pipe[s] <= '0;
        end else begin
          pipe[0] <= vec_in[i*DW +: DW];
          for (int s = 1; s < i; s++) pipe[s] <= pipe[s-1];
        end
      end
      assign vec_out[i*DW +: DW] = pipe[i-1];
    end
  end
endmodule

// File: rtl/apsa_pe.sv
module apsa_pe
  import apsa_pkg::*;
#(
  parameter int PW = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [WORD_W-1:0]      load_word,
  input  logic [SLICES-1:0]      sign_mask,
  input  logic [ACT_W-1:0]       act_in,
  input  logic [SLICES*PW-1:0]   psum_in,
  output logic [SLICES*PW-1:0]   psum_out,
  output logic [WORD_W-1:0]      weight_out
);
  logic [WORD_W-1:0]          w_q;
  logic signed [PROD_W-1:0]   prod [SLICES];
  logic [SLICES*PW-1:0]       psum_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n)       w_q <= '0;
    else if (load_en) w_q <= load_word;
  end

  always_comb begin
    for (int s = 0; s < SLICES; s++) begin
      prod[s] = slice_mul($signed(act_in), w_q[s*SLICE_W +: SLICE_W], sign_mask[s]);
      psum_nxt[s*PW +: PW] = $signed(psum_in[s*PW +: PW]) + PW'(prod[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) psum_out <= '0;
    else        psum_out <= psum_nxt;
  end

  assign weight_out = w_q;
endmodule

// File: rtl/apsa_col_acc.sv
module apsa_col_acc
  import apsa_pkg::*;
#(
  parameter int PW = 13,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 acc_en,
  input  prec_mode_e           mode,
  input  logic [SLICES*PW-1:0] psum,
  output logic [SLICES*AW-1:0] acc_out
);
  // Recombine the four slice sums into lane addends for the given precision.
  function automatic logic [SLICES*AW-1:0] combine(logic [SLICES*PW-1:0] p, prec_mode_e m);
    logic signed [AW-1:0] s [SLICES];
    logic [SLICES*AW-1:0] r;
    for (int k = 0; k < SLICES; k++) s[k] = AW'($signed(p[k*PW +: PW]));
    r = '0;
    case (m)
      PM_W4: begin
        r[0*AW +: AW] = s[0] + (s[1] <<< 2);
        r[1*AW +: AW] = s[2] + (s[3] <<< 2);
      end
      PM_W2: begin
        for (int k = 0; k < SLICES; k++) r[k*AW +: AW] = s[k];
      end
      default: begin
        r[0*AW +: AW] = s[0] + (s[1] <<< 2) + (s[2] <<< 4) + (s[3] <<< 6);
      end
    endcase
    return r;
  endfunction

  logic [SLICES*AW-1:0] lane_add;
  logic [AW-1:0]        acc_q [SLICES];

  assign lane_add = combine(psum, mode);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int l = 0; l < SLICES; l++) acc_q[l] <= '0;
    end else if (acc_en) begin
      for (int l = 0; l < SLICES; l++) acc_q[l] <= acc_q[l] + lane_add[l*AW +: AW];
    end
  end

  for (genvar l = 0; l < SLICES; l++) begin : g_out
    assign acc_out[l*AW +: AW] = acc_q[l];
  end

  // R6: a clear leaves every lane at zero on the next cycle.
  p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q[0] == '0 && acc_q[1] == '0 && acc_q[2] == '0 && acc_q[3] == '0));

  // R2: the fused 8-bit combination feeds nothing into the spare lanes.
  p_spare_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_W8) |-> (lane_add[SLICES*AW-1:AW] == '0));

  // R3: 4-bit mode leaves lanes 2 and 3 untouched.
  p_spare_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_W4) |-> (lane_add[SLICES*AW-1:2*AW] == '0));
endmodule

// File: rtl/apsa_top.sv
module apsa_top
  import apsa_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               mode_sel,
  input  logic [LW-1:0]            tile_len,
  input  logic                     w_load,
  input  logic [((N>1)?$clog2(N):1)-1:0] w_col,
  input  logic [N*WORD_W-1:0]      w_word,
  input  logic                     act_valid,
  input  logic [N*ACT_W-1:0]       act_vec,
  output logic                     busy,
  output logic                     done,
  output logic [N*SLICES*AW-1:0]   result
);
  localparam int CW  = (N > 1) ? $clog2(N) : 1;
  localparam int PW  = PROD_W + $clog2(N) + 1;
  localparam int DCW = $clog2(2*N) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} tile_st_e;

  tile_st_e         st_q;
  prec_mode_e       mode_q;
  logic [LW-1:0]    len_q, beat_q;
  logic [DCW-1:0]   drain_q;
  logic             done_q;

  // Named internal events.
  logic             start_take;
  logic             beat_take;
  logic             last_beat;
  logic             acc_en;
  logic [SLICES-1:0] sign_mask;
  logic [N*ACT_W-1:0] feed_vec, skew_vec;
  logic [N-1:0]     col_load;
  logic [N*N*WORD_W-1:0] pe_w_flat;

  assign start_take = (st_q == ST_IDLE) && start;
  assign beat_take  = (st_q == ST_RUN) && act_valid;
  assign last_beat  = beat_take && (beat_q == len_q - LW'(1));
  assign acc_en     = (st_q != ST_IDLE);
  assign sign_mask  = slice_sign_mask(mode_q);
  assign feed_vec   = beat_take ? act_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= PM_W8;
      len_q   <= '0;
      beat_q  <= '0;
      drain_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_take) begin
          st_q   <= ST_RUN;
          mode_q <= prec_mode_e'(mode_sel);
          len_q  <= (tile_len == '0) ? LW'(1) : tile_len;
          beat_q <= '0;
        end
        ST_RUN: if (beat_take) begin
          if (last_beat) begin
            st_q    <= ST_DRAIN;
            drain_q <= '0;
          end else begin
            beat_q <= beat_q + LW'(1);
          end
        end
        ST_DRAIN: begin
          if (drain_q == DCW'(2*N-2)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            drain_q <= drain_q + DCW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  apsa_skew #(.N(N), .DW(ACT_W)) i_skew (
    .clk(clk), .rst_n(rst_n), .vec_in(feed_vec), .vec_out(skew_vec)
  );

  logic [ACT_W-1:0]     act_h  [N][N];
  logic [SLICES*PW-1:0] psum_v [N+1][N];

  for (genvar j = 0; j < N; j++) begin : g_colsel
    assign col_load[j] = w_load && !busy && (w_col == CW'(j));
    assign psum_v[0][j] = '0;
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    assign act_h[i][0] = skew_vec[i*ACT_W +: ACT_W];
    for (genvar j = 1; j < N; j++) begin : g_hop
      always_ff @(posedge clk) begin
        if (!rst_n) act_h[i][j] <= '0;
        else        act_h[i][j] <= act_h[i][j-1];
      end
    end
    for (genvar j = 0; j < N; j++) begin : g_pe
      apsa_pe #(.PW(PW)) i_pe (
        .clk(clk), .rst_n(rst_n),
        .load_en(col_load[j]),
        .load_word(w_word[i*WORD_W +: WORD_W]),
        .sign_mask(sign_mask),
        .act_in(act_h[i][j]),
        .psum_in(psum_v[i][j]),
        .psum_out(psum_v[i+1][j]),
        .weight_out(pe_w_flat[(i*N+j)*WORD_W +: WORD_W])
      );
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_acc
    apsa_col_acc #(.PW(PW), .AW(AW)) i_col (
      .clk(clk), .rst_n(rst_n),
      .clr(start_take), .acc_en(acc_en), .mode(mode_q),
      .psum(psum_v[N][j]),
      .acc_out(result[j*SLICES*AW +: SLICES*AW])
    );
  end

  // R5: done is a single-cycle pulse.
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: done only follows the drain phase, and the array is idle with it.
  p_done_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st_q == ST_DRAIN) && !busy));

  // R7: the latched precision holds for the whole tile.
  p_mode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

  // R8: no stored weight moves while a tile runs.
  p_weights_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pe_w_flat));

  // R9: beats are counted only in the run phase.
  p_beat_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !act_valid) |=> (st_q == ST_RUN && $stable(beat_q)));
endmodule

// File: tb/test_apsa_top.sv
module test_apsa_top;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int KMAX = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [15:0] tile_len = 16'd1;
  logic w_load = 1'b0;
  logic [1:0] w_col = 2'd0;
  logic [N*8-1:0] w_word = '0;
  logic act_valid = 1'b0;
  logic [N*8-1:0] act_vec = '0;
  logic busy, done;
  logic [N*4*AW-1:0] result;

  apsa_top #(.N(N), .AW(AW), .LW(16)) i_apsa_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .tile_len(tile_len),
    .w_load(w_load), .w_col(w_col), .w_word(w_word), .act_valid(act_valid),
    .act_vec(act_vec), .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] wgt [N][N];
  int act [KMAX][N];

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Weight value seen by a lane, decoded from the word by plain integer arithmetic.
  function automatic int lane_weight(logic [7:0] w, int mode, int lane);
    int u, f;
    u = int'(w);
    if (mode == 1) begin
      if (lane > 1) return 0;
      f = (u >> (4*lane)) % 16;
      return (f >= 8) ? f - 16 : f;
    end else if (mode == 2) begin
      f = (u >> (2*lane)) % 4;
      return (f >= 2) ? f - 4 : f;
    end
    if (lane != 0) return 0;
    return (u >= 128) ? u - 256 : u;
  endfunction

  task automatic load_weights();
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      w_load = 1'b1;
      w_col = 2'(j);
      for (int i = 0; i < N; i++) w_word[i*8 +: 8] = wgt[i][j];
    end
    @(negedge clk);
    w_load = 1'b0;
  endtask

  // Runs one tile and checks timing and every lane against the arithmetic model.
  task automatic run_tile(int mode, int klen, bit bubbles, bit disturb, string tag);
    int m;
    longint exp;
    @(negedge clk);
    start = 1'b1;
    mode_sel = 2'(mode);
    tile_len = 16'(klen);
    for (int k = 0; k < klen; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 0) check({tag, " R5 busy after start"}, longint'(busy), 1);
      if (disturb) begin
        mode_sel = 2'((mode + 1) % 3);
        w_load = 1'b1;
        w_col = 2'(k % N);
        w_word = '1;
      end
      if (bubbles && (k % 2 == 1)) begin
        act_valid = 1'b0;
        act_vec = 32'h7F80_7F80 ^ 32'(k * 32'h0101_0101);
        @(negedge clk);
      end
      act_valid = 1'b1;
      for (int i = 0; i < N; i++) act_vec[i*8 +: 8] = 8'(act[k][i]);
    end
    @(negedge clk);
    act_valid = 1'b0;
    act_vec = '0;
    w_load = 1'b0;
    m = 0;
    for (int t = 0; t < 40; t++) begin
      if (done) break;
      @(negedge clk);
      m++;
    end
    check({tag, " R5 done delay"}, m, 2*N-1);
    check({tag, " R5 busy low at done"}, longint'(busy), 0);
    for (int j = 0; j < N; j++) begin
      for (int l = 0; l < 4; l++) begin
        exp = 0;
        for (int k = 0; k < klen; k++)
          for (int i = 0; i < N; i++)
            exp += longint'(act[k][i]) * lane_weight(wgt[i][j], mode, l);
        check($sformatf("%s R10 col%0d lane%0d", tag, j, l),
              longint'($signed(result[(j*4+l)*AW +: AW])), exp);
      end
    end
    @(negedge clk);
    check({tag, " R5 done one cycle"}, longint'(done), 0);
  endtask

  task automatic random_tile(int mode, int klen, bit bubbles, bit disturb, bit reload, string tag);
    if (reload) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) wgt[i][j] = 8'($urandom);
      load_weights();
    end
    for (int k = 0; k < klen; k++)
      for (int i = 0; i < N; i++) act[k][i] = int'($signed(8'($urandom)));
    run_tile(mode, klen, bubbles, disturb, tag);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    wrap_up();
  end

  initial begin
    int avals [5];
    avals = '{-128, -1, 1, 127, -77};
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state.
    check("R1 busy", longint'(busy), 0);
    check("R1 done", longint'(done), 0);
    check("R1 result zero", longint'(result == '0), 1);

    // R2 corner: every operand -128 in 8-bit mode.
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wgt[i][j] = 8'h80;
    load_weights();
    for (int k = 0; k < 5; k++) for (int i = 0; i < N; i++) act[k][i] = -128;
    run_tile(0, 5, 0, 0, "R2 min x min");

    // R4 corner: every 2-bit weight is -2.
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wgt[i][j] = 8'hAA;
    load_weights();
    for (int k = 0; k < 3; k++) for (int i = 0; i < N; i++) act[k][i] = (i % 2 == 0) ? 127 : -128;
    run_tile(2, 3, 0, 0, "R4 minus two");

    // R2 R3 R4: sweep every weight byte against extreme activations, one row at a time.
    for (int w = 0; w < 256; w++) begin
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wgt[i][j] = (j == w % N) ? 8'(w) : 8'(w ^ 8'h5A);
      load_weights();
      for (int a = 0; a < 5; a++) begin
        for (int i = 0; i < N; i++) act[0][i] = (i == (w + a) % N) ? avals[a] : 0;
        run_tile(w % 3, 1, 0, 0, (w % 3 == 0) ? "R2 sweep" : (w % 3 == 1) ? "R3 sweep" : "R4 sweep");
      end
    end

    // Random tiles in each mode; R6 back-to-back tiles without reload.
    for (int md = 0; md < 3; md++) begin
      random_tile(md, 1 + int'($urandom % 8), 0, 0, 1, "R6 first");
      random_tile(md, 1 + int'($urandom % 8), 0, 0, 0, "R6 second");
      // R9: bubbles with garbage data.
      random_tile(md, 6, 1, 0, 0, "R9 bubbles");
      // R7 R8: mode and weight writes while busy are ignored.
      random_tile(md, 5, 0, 1, 1, "R7 R8 disturb");
      random_tile(md, 4, 0, 0, 0, "R8 after disturb");
      random_tile(md, KMAX, 1, 0, 1, "R2 R3 R4 long");
    end

    repeat (3) @(negedge clk);
    wrap_up();
  end
endmodule